// File: doc/BRIEF.md
# Serial Flash Boot Loader with Address-Width Discovery

This block is an SPI master that pulls a boot image out of a single serial EEPROM or flash part whose address length is not known at reset. After a start pulse it selects the device, sends a read command and then sends zero bytes one at a time. The first address byte is always sent. Every zero byte after it is also treated as a probe: the byte that comes back on MISO at the same time is checked. A pulled-up, idle line reads 0xFF. The first probe that returns something other than 0xFF shows how many address bytes the device consumed. That byte is also the first byte of the image.

From then on the master keeps clocking and delivers the image as a stream of bytes, each marked by a one-cycle valid pulse. Once the requested number of bytes has arrived, it releases chip-select and raises a done flag. If four address bytes have gone out and the line still reads 0xFF, it gives up: it releases chip-select and raises an error flag. The SCK rate comes from a divider register that starts at its slowest useful value after reset. The register can be rewritten while the block is idle.

Top module: `spi_boot_probe`

## Requirements
- R1: After reset, cs_no is high, sck_o is low, done_o, err_o and data_valid_o are low, and the divider register holds 0x85 (SCK half period of 134 clk_i cycles).
- R2: Each SCK high phase and each SCK low phase lasts div+1 clk_i cycles, where div is the divider register. A div_we_i pulse loads div_i only while idle. A pulse during a transfer has no effect.
- R3: SPI mode 0, MSB first. sck_o idles low, mosi_o changes only while sck_o is low, and miso_i is sampled on the rising SCK edge.
- R4: A start_i pulse while idle pulls cs_no low, and the first byte sent is the read command 0x03. A start_i pulse during a transfer is ignored.
- R5: Every byte sent after the command is 0x00. The first byte after the command is an address byte whose response is not examined. Each later byte is a probe whose response is examined.
- R6: If the first probe response that is not 0xFF comes after k address bytes (k = 1 to 4), width_o reports k-1 (0 means 8-bit, 1 means 16-bit, 2 means 24-bit, 3 means 32-bit addressing).
- R7: The first response that is not 0xFF is output as data byte 0. Further bytes follow until len_i bytes in total have been output (len_i = 0 counts as 1). Each byte appears on data_o with a one-cycle data_valid_o pulse, and only while cs_no was low in the cycle before.
- R8: cs_no stays low for the whole transfer and rises once, just after the last data byte. At the same time done_o goes high and stays high until the next start. The transfer uses exactly (1 + k + bytes) x 8 SCK rising edges.
- R9: If the fourth probe (after four address bytes) still returns 0xFF, cs_no rises after 48 SCK rising edges in total. err_o goes high and no data_valid_o pulse is produced. done_o and err_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| div_we_i | input | 1 | Divider register write strobe (idle only) |
| div_i | input | 8 | New divider value |
| len_i | input | 16 | Number of image bytes to read, sampled at start |
| miso_i | input | 1 | Serial data from the device |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the device |
| cs_no | output | 1 | Device select, active low |
| width_o | output | 2 | Detected address-width code |
| data_o | output | 8 | Received image byte |
| data_valid_o | output | 1 | One-cycle strobe for data_o |
| done_o | output | 1 | Transfer completed |
| err_o | output | 1 | No device response after four address bytes |

## Verification
The hardest state to reach is the point where one probe byte is both the last extra address byte and the first image byte. Reaching it means the device must answer 0xFF for exactly the right number of probes and then answer with something else. The bench plays the device. It counts the SCK edges under chip-select and drives the pulled-up level until it has consumed its own number of address bytes. After that it serves image bytes whose first byte is never 0xFF. The bench chooses the address length at random, including an absent device, and mixes in directed runs at the slowest divider and with start and divider writes sent in the middle of a transfer.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;
  localparam int unsigned ADDR_MAX = 4;
  localparam int unsigned WCODE_W  = $clog2(ADDR_MAX);
  localparam logic [7:0]  IDLE_BYTE = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_PROBE,
    ST_DATA
  } boot_st_e;
endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sck_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             tick;

  assign tick   = en_i && (cnt_q >= div_i);
  assign rise_o = tick && !sck_o;
  assign fall_o = tick && sck_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      sck_o <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sck_o <= ~sck_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_byte_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [BYTE_W-1:0] rx_o,
  output logic              byte_done_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] tx_q;
  logic [CNT_W-1:0]  bit_q;

  assign mosi_o      = tx_q[BYTE_W-1];
  assign byte_done_o = fall_i && (bit_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      bit_q <= '0;
    end else if (load_i) begin
      tx_q  <= load_byte_i;
      bit_q <= '0;
    end else if (fall_i) begin
      tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
      bit_q <= bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rx_o <= '0;
    else if (rise_i) rx_o <= {rx_o[BYTE_W-2:0], miso_i};
  end
endmodule

// File: rtl/spi_boot_probe.sv
module spi_boot_probe
  import spi_boot_pkg::*;
#(
  parameter int unsigned DIV_W   = 8,
  parameter logic [7:0]  DIV_RST = 8'h85,
  parameter int unsigned LEN_W   = 16,
  parameter logic [7:0]  CMD_RD  = 8'h03
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             div_we_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             miso_i,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             cs_no,
  output logic [1:0]       width_o,
  output logic [7:0]       data_o,
  output logic             data_valid_o,
  output logic             done_o,
  output logic             err_o
);
  localparam logic [WCODE_W-1:0] LAST_PROBE = WCODE_W'(ADDR_MAX - 1);

  boot_st_e st_q, st_d;
  logic [DIV_W-1:0]   div_q;
  logic [LEN_W-1:0]   left_q;
  logic [WCODE_W-1:0] probe_q, width_q;
  logic [7:0]         data_q, rx, ld_byte;
  logic valid_q, done_q, err_q;
  logic rise, fall, byte_done, ld, emit, fin_ok, fin_err, last, idle, hit;

  assign idle    = (st_q == ST_IDLE);
  assign last    = (left_q == LEN_W'(1));
  assign hit     = (rx != IDLE_BYTE);
  assign ld_byte = idle ? CMD_RD : 8'h00;

  spi_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (!idle), .div_i (div_q),
    .sck_o (sck_o), .rise_o (rise), .fall_o (fall)
  );

  spi_byte_shift #(.BYTE_W(8)) u_shift (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (ld), .load_byte_i (ld_byte),
    .rise_i (rise), .fall_i (fall), .miso_i (miso_i),
    .mosi_o (mosi_o), .rx_o (rx), .byte_done_o (byte_done)
  );

  always_comb begin
    st_d    = st_q;
    ld      = 1'b0;
    emit    = 1'b0;
    fin_ok  = 1'b0;
    fin_err = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (start_i) begin st_d = ST_CMD; ld = 1'b1; end
      ST_CMD:   if (byte_done) begin st_d = ST_ADDR; ld = 1'b1; end
      ST_ADDR:  if (byte_done) begin st_d = ST_PROBE; ld = 1'b1; end
      ST_PROBE: if (byte_done) begin
        if (hit) begin
          emit = 1'b1;
          if (last) begin st_d = ST_IDLE; fin_ok = 1'b1; end
          else begin st_d = ST_DATA; ld = 1'b1; end
        end else if (probe_q == LAST_PROBE) begin
          st_d    = ST_IDLE;
          fin_err = 1'b1;
        end else begin
          ld = 1'b1;
        end
      end
      ST_DATA:  if (byte_done) begin
        emit = 1'b1;
        if (last) begin st_d = ST_IDLE; fin_ok = 1'b1; end
        else ld = 1'b1;
      end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      div_q   <= DIV_RST;
      left_q  <= '0;
      probe_q <= '0;
      width_q <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      valid_q <= emit;
      if (idle && div_we_i) div_q <= div_i;
      if (idle && start_i) begin
        left_q  <= (len_i == '0) ? LEN_W'(1) : len_i;
        probe_q <= '0;
        width_q <= '0;
        done_q  <= 1'b0;
        err_q   <= 1'b0;
      end
      if (st_q == ST_PROBE && byte_done && !hit && probe_q != LAST_PROBE)
        probe_q <= probe_q + 1'b1;
      if (emit) begin
        data_q <= rx;
        left_q <= left_q - 1'b1;
        if (st_q == ST_PROBE) width_q <= probe_q;
      end
      if (fin_ok)  done_q <= 1'b1;
      if (fin_err) err_q  <= 1'b1;
    end
  end

  assign cs_no        = idle;
  assign width_o      = 2'(width_q);
  assign data_o       = data_q;
  assign data_valid_o = valid_q;
  assign done_o       = done_q;
  assign err_o        = err_q;
endmodule

// File: rtl/spi_boot_probe_chk.sv
module spi_boot_probe_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_no,
  input logic sck_o,
  input logic mosi_o,
  input logic data_valid_o,
  input logic done_o,
  input logic err_o
);
  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o); // R3
  AST_MOSI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> $stable(mosi_o)); // R3
  AST_VALID_IN_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> $past(!cs_no)); // R7
  AST_DONE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> cs_no); // R8
  AST_ERR_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !data_valid_o); // R9
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o)); // R9
endmodule

bind spi_boot_probe spi_boot_probe_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_no        (cs_no),
  .sck_o        (sck_o),
  .mosi_o       (mosi_o),
  .data_valid_o (data_valid_o),
  .done_o       (done_o),
  .err_o        (err_o)
);

// File: tb/spi_boot_probe_bench.sv
module spi_boot_probe_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, div_we = 1'b0;
  logic [7:0] div_in = 8'd0;
  logic [15:0] len_in = 16'd0;
  logic miso, sck, mosi, cs_n, dv, done, err;
  logic [1:0] width;
  logic [7:0] dout;

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  bit active = 1'b0;
  int dev_a = 0, bitn = 0, rises = 0, hi_start = 0, hi_min = 0, hi_max = 0;
  int cs_rises = 0, ngot = 0;
  logic miso_r = 1'b1;
  logic [7:0] mem [8];
  logic [7:0] mo [16];
  logic [7:0] got [16];

  always #10 clk = ~clk;
  always @(negedge clk) cyc++;

  assign miso = cs_n ? 1'b1 : miso_r;

  spi_boot_probe u_spi_boot_probe (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .div_we_i (div_we),
    .div_i (div_in), .len_i (len_in), .miso_i (miso), .sck_o (sck),
    .mosi_o (mosi), .cs_no (cs_n), .width_o (width), .data_o (dout),
    .data_valid_o (dv), .done_o (done), .err_o (err)
  );

  function automatic logic bit_at(int n);
    int b = n / 8;
    if (dev_a == 0 || b < 1 + dev_a || b - 1 - dev_a >= 8) return 1'b1;
    return mem[b-1-dev_a][7-(n%8)];
  endfunction

  always @(negedge cs_n) if (active) begin bitn = 0; miso_r = bit_at(0); end
  always @(posedge cs_n) if (active) cs_rises++;
  always @(posedge sck) if (active) begin
    rises++;
    if (bitn / 8 < 16) mo[bitn/8][7-(bitn%8)] = mosi;
    hi_start = cyc;
  end
  always @(negedge sck) if (active) begin
    if (cyc - hi_start < hi_min) hi_min = cyc - hi_start;
    if (cyc - hi_start > hi_max) hi_max = cyc - hi_start;
    bitn++;
    miso_r = bit_at(bitn);
  end
  always @(negedge clk) if (dv === 1'b1 && ngot < 16) begin got[ngot] = dout; ngot++; end

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(int div, int a, int len, bit load, bit poke);
    int eff = (len == 0) ? 1 : len;
    int nz = 0;
    int t = 0;
    if (load) begin
      @(negedge clk); div_we = 1'b1; div_in = 8'(div);
      @(negedge clk); div_we = 1'b0;
    end
    dev_a = a;
    for (int i = 0; i < 8; i++) mem[i] = 8'($urandom);
    if (mem[0] == 8'hFF) mem[0] = 8'h5A;
    for (int i = 0; i < 16; i++) mo[i] = 8'h00;
    rises = 0; hi_min = 1000000; hi_max = 0; ngot = 0; cs_rises = 0; bitn = 0;
    active = 1'b1;
    @(negedge clk); start = 1'b1; len_in = 16'(len);
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (30) @(negedge clk);
      start = 1'b1; div_we = 1'b1; div_in = 8'(div + 5);
      @(negedge clk); start = 1'b0; div_we = 1'b0;
    end
    while (!(done || err) && t < 40000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    active = 1'b0;
    chk("R8", "done", int'(done), int'(a != 0));
    chk("R9", "err", int'(err), int'(a == 0));
    chk("R8", "cs released once", cs_rises, 1);
    chk("R8", "cs high after", int'(cs_n), 1);
    chk("R8", "sck rising edges", rises, (a == 0) ? 48 : (1 + a + eff) * 8);
    chk("R4", "command byte", int'(mo[0]), 3);
    for (int i = 1; i < 16; i++) if (mo[i] != 8'h00) nz++;
    chk("R5", "nonzero address/probe bytes", nz, 0);
    chk("R2", "min high phase", hi_min, div + 1);
    chk("R2", "max high phase", hi_max, div + 1);
    if (a == 0) chk("R9", "data bytes", ngot, 0);
    else begin
      chk("R6", "width code", int'(width), a - 1);
      chk("R7", "data bytes", ngot, eff);
      for (int i = 0; i < eff && i < ngot; i++) chk("R7", "data value", int'(got[i]), int'(mem[i]));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1", "cs_no at reset", int'(cs_n), 1);
    chk("R1", "sck at reset", int'(sck), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "flags after reset", int'({done, err, dv}), 0);
    chk("R1", "sck idle", int'(sck), 0);
    run(133, 1, 1, 1'b0, 1'b0);      // R1 default divider 0x85
    run(0, 4, 3, 1'b1, 1'b0);        // R6 widest address, fastest clock
    run(1, 2, 0, 1'b1, 1'b0);        // R7 zero length counts as one
    run(2, 0, 2, 1'b1, 1'b0);        // R9 absent device
    run(2, 3, 4, 1'b1, 1'b1);        // R4 R2 start and divider write mid-transfer
    mem[0] = 8'h00;
    for (int k = 0; k < 10; k++)
      run(int'($urandom_range(0, 3)), int'($urandom_range(0, 4)), int'($urandom_range(0, 6)), 1'b1, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule